// File: doc/BRIEF.md
# Store-Triggered Trace Capture Unit

This unit sits next to the memory controller and watches the CPU store bus for writes to a two-word reserved window. A write to that window does not reach normal memory. Instead it drives the trace logic. The even word holds an event identifier. A write to the odd word supplies a software timestamp and turns the pair into one trace record.

The unit stamps each committed record with a free-running cycle count, taken in the cycle of the commit. It then pushes the record into a small circular buffer. An independent reader drains the buffer through a valid/ready port, oldest record first. Each record on that port carries a fixed core identifier beside the program's data. The CPU store is accepted every cycle with no wait state. When the buffer is full, a new commit replaces the oldest record and raises a sticky overflow flag.

Top module: `trace_capture`

## Requirements
- R1: A store whose word address is neither WIN_BASE nor WIN_BASE+1 (WIN_BASE even) is passed on, so mem_st_valid_o equals st_valid_i in that cycle. A store to either window word holds mem_st_valid_o low.
- R2: A store to WIN_BASE latches st_data_i as the pending event identifier and creates no record. The unit keeps the last such value (0 after reset).
- R3: A store to WIN_BASE+1 commits a record holding the pending event identifier and st_data_i as the software timestamp. rec_valid_o is high from the cycle after the commit edge.
- R4: rec_core_o always equals the CORE_ID parameter.
- R5: rec_stamp_o is the cycle counter value in the commit cycle. The counter is 0 during reset and increments at every clock edge after reset is released.
- R6: Records leave in commit order. Exactly one record is removed per cycle in which rec_valid_o and rec_ready_i are both high.
- R7: A commit into a full buffer (DEPTH records) in a cycle with no drain overwrites the oldest record and sets ovf_o. ovf_o stays set until reset.
- R8: A commit into a full buffer in the same cycle as a drain loses no record and leaves ovf_o clear.
- R9: After reset, rec_valid_o and ovf_o are low.
- R10: While rec_valid_o is high and rec_ready_i is low, the record fields hold steady. The one exception is a cycle with an overwriting commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| st_valid_i | input | 1 | CPU store strobe |
| st_addr_i | input | AW | CPU store word address |
| st_data_i | input | DW | CPU store data |
| mem_st_valid_o | output | 1 | Store strobe forwarded to memory, masked for the window |
| rec_valid_o | output | 1 | Record available on drain port |
| rec_ready_i | input | 1 | Reader accepts the presented record |
| rec_core_o | output | CIDW | Core identifier of the record |
| rec_event_o | output | DW | Event identifier of the record |
| rec_swts_o | output | DW | Software timestamp of the record |
| rec_stamp_o | output | CW | Cycle counter value at commit |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The hardest situations to reach are the full-buffer corner cases. One is a commit that lands while the reader is idle, which must overwrite the oldest record. The other is a commit that lands in the very cycle the reader takes the head, which must not overwrite. The bench sweeps the number of back-to-back commits from zero to well past the buffer depth with the reader held off, then drains. The counts and the surviving records show exactly where the overwrite starts. A separate run fills the buffer and lines up a commit and a drain on the same edge.

// File: rtl/trace_pkg.sv
package trace_pkg;
  typedef enum logic [1:0] {
    SLOT_NONE   = 2'd0,
    SLOT_EVENT  = 2'd1,
    SLOT_COMMIT = 2'd2
  } slot_e;
endpackage

// File: rtl/trace_window.sv
module trace_window
  import trace_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] WIN_BASE = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          st_valid_i,
  input  logic [AW-1:0] st_addr_i,
  output slot_e         slot_o,
  output logic          mem_st_valid_o
);
  logic hit;
  assign hit = st_addr_i[AW-1:1] == WIN_BASE[AW-1:1];

  always_comb begin
    slot_o = SLOT_NONE;
    if (st_valid_i && hit) slot_o = st_addr_i[0] ? SLOT_COMMIT : SLOT_EVENT;
  end

  assign mem_st_valid_o = st_valid_i & ~hit;

  assert_window_masked_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_o != SLOT_NONE) |-> !mem_st_valid_o);
endmodule

// File: rtl/trace_stamp.sv
module trace_stamp #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/trace_ring.sv
module trace_ring #(
  parameter int unsigned W     = 48,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] data_o,
  output logic         ovf_o
);
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNTW = $clog2(DEPTH + 1);
  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);

  logic [W-1:0]    mem [DEPTH];
  logic [PW-1:0]   wr_q, rd_q;
  logic [CNTW-1:0] cnt_q;
  logic            pop, full, clobber;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign valid_o = cnt_q != '0;
  assign data_o  = mem[rd_q];
  assign pop     = valid_o & ready_i;
  assign full    = cnt_q == FULL_CNT;
  assign clobber = push_i & full & ~pop;  // oldest entry replaced

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop || clobber) rd_q <= nxt(rd_q);
      if (push_i && !pop && !full) cnt_q <= cnt_q + 1'b1;
      else if (pop && !push_i)     cnt_q <= cnt_q - 1'b1;
      if (clobber) ovf_o <= 1'b1;
    end
  end

  assert_count_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT);
  assert_ovf_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  assert_push_visible_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> valid_o);
  assert_one_pop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && !push_i) |=> cnt_q == $past(cnt_q) - 1'b1);
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && !push_i) |=> valid_o && $stable(data_o));
  assert_no_ovf_on_pop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop && !ovf_o) |=> !ovf_o);
endmodule

// File: rtl/trace_capture.sv
module trace_capture
  import trace_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 16,
  parameter int unsigned CW    = 16,
  parameter int unsigned CIDW  = 4,
  parameter int unsigned DEPTH = 4,
  parameter logic [AW-1:0]   WIN_BASE = 16'hFF00,
  parameter logic [CIDW-1:0] CORE_ID  = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            st_valid_i,
  input  logic [AW-1:0]   st_addr_i,
  input  logic [DW-1:0]   st_data_i,
  output logic            mem_st_valid_o,
  output logic            rec_valid_o,
  input  logic            rec_ready_i,
  output logic [CIDW-1:0] rec_core_o,
  output logic [DW-1:0]   rec_event_o,
  output logic [DW-1:0]   rec_swts_o,
  output logic [CW-1:0]   rec_stamp_o,
  output logic            ovf_o
);
  localparam int unsigned RW = 2 * DW + CW;

  slot_e         slot;
  logic [DW-1:0] event_q;
  logic [CW-1:0] stamp;
  logic [RW-1:0] rec_in, rec_out;

  trace_window #(.AW(AW), .WIN_BASE(WIN_BASE)) u_window (
    .clk_i, .rst_ni, .st_valid_i, .st_addr_i,
    .slot_o(slot), .mem_st_valid_o
  );

  trace_stamp #(.CW(CW)) u_stamp (.clk_i, .rst_ni, .cnt_o(stamp));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 event_q <= '0;
    else if (slot == SLOT_EVENT) event_q <= st_data_i;
  end

  assign rec_in = {event_q, st_data_i, stamp};

  trace_ring #(.W(RW), .DEPTH(DEPTH)) u_ring (
    .clk_i, .rst_ni,
    .push_i(slot == SLOT_COMMIT), .data_i(rec_in),
    .valid_o(rec_valid_o), .ready_i(rec_ready_i),
    .data_o(rec_out), .ovf_o
  );

  assign rec_core_o  = CORE_ID;
  assign rec_event_o = rec_out[RW-1 -: DW];
  assign rec_swts_o  = rec_out[CW +: DW];
  assign rec_stamp_o = rec_out[CW-1:0];

  assert_event_no_record_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot == SLOT_EVENT && !rec_valid_o) |=> !rec_valid_o);
endmodule

// File: tb/trace_capture_bench.sv
module trace_capture_bench;
  localparam logic [15:0] BASE = 16'hFF00;
  localparam logic [3:0]  CID  = 4'd9;
  localparam int          DEP  = 4;

  logic clk = 0, rst_n = 0;
  logic st_valid = 0, rec_ready = 0;
  logic [15:0] st_addr = 0, st_data = 0;
  logic mem_v, rec_valid, ovf;
  logic [3:0] rec_core;
  logic [15:0] rec_event, rec_swts, rec_stamp;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [15:0] cyc, ev_lat;
  logic [47:0] mq[$];

  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  trace_capture #(.DEPTH(DEP), .WIN_BASE(BASE), .CORE_ID(CID)) u_trace_capture (
    .clk_i(clk), .rst_ni(rst_n), .st_valid_i(st_valid), .st_addr_i(st_addr),
    .st_data_i(st_data), .mem_st_valid_o(mem_v), .rec_valid_o(rec_valid),
    .rec_ready_i(rec_ready), .rec_core_o(rec_core), .rec_event_o(rec_event),
    .rec_swts_o(rec_swts), .rec_stamp_o(rec_stamp), .ovf_o(ovf)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; st_valid = 0; rec_ready = 0; ev_lat = 0; mq.delete();
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1;
  endtask

  // one store; 'pop' also asserts ready in the same cycle (R8)
  task automatic store(logic [15:0] a, logic [15:0] d, bit pop = 0);
    bit win;
    @(negedge clk);
    st_valid = 1; st_addr = a; st_data = d; rec_ready = pop;
    #1;
    win = (a[15:1] == BASE[15:1]);
    check("R1", mem_v, !win);
    if (pop) begin
      check("R8 head", {rec_event, rec_swts, rec_stamp}, mq.pop_front());
    end
    if (win && !a[0]) ev_lat = d;
    if (win && a[0]) begin
      if (mq.size() == DEP) void'(mq.pop_front());
      mq.push_back({ev_lat, d, cyc});
    end
    @(posedge clk); #1;
    st_valid = 0; rec_ready = 0;
  endtask

  task automatic drain(output int n);
    n = 0;
    @(negedge clk);
    while (rec_valid && n < 10) begin
      check("R4", rec_core, CID);
      check("R6 R3 R5 record", {rec_event, rec_swts, rec_stamp},
            (mq.size() > 0) ? mq.pop_front() : 48'hX);
      rec_ready = 1;
      @(posedge clk); #1;
      rec_ready = 0;
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=running exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int got;
    do_reset();
    #1;
    check("R9 valid", rec_valid, 0);
    check("R9 ovf", ovf, 0);

    // R1: addresses around the window
    store(BASE - 1, 16'h1111);
    store(BASE + 2, 16'h2222);
    store(16'h0000, 16'h3333);
    check("R1 no record", rec_valid, 0);

    // R2: event write alone makes no record
    store(BASE, 16'h00E1);
    check("R2", rec_valid, 0);
    repeat (3) @(posedge clk);
    #1 check("R2 still", rec_valid, 0);
    store(BASE + 1, 16'hBEEF);
    check("R3 valid", rec_valid, 1);
    drain(got);
    check("R6 count", got, 1);

    // sweep commit counts with reader held off (R6, R7)
    for (int n = 0; n <= 7; n++) begin
      do_reset();
      for (int i = 0; i < n; i++) begin
        store(BASE, 16'h0100 + 16'(i));
        store(BASE + 1, 16'hA000 + 16'(n * 16 + i));
        repeat (i % 2) @(posedge clk);
      end
      #1 check("R7 ovf", ovf, n > DEP);
      drain(got);
      check("R6 drained", got, (n > DEP) ? DEP : n);
      check("R7 sticky", ovf, n > DEP);
    end

    // R10: hold with reader idle
    do_reset();
    store(BASE, 16'h0042);
    store(BASE + 1, 16'h0007);
    store(BASE + 1, 16'h0008);
    @(negedge clk);
    begin
      logic [47:0] h;
      h = {rec_event, rec_swts, rec_stamp};
      repeat (3) @(negedge clk);
      check("R10 valid", rec_valid, 1);
      check("R10 stable", {rec_event, rec_swts, rec_stamp}, h);
    end
    drain(got);
    check("R10 count", got, 2);

    // R8: commit into full buffer while draining
    do_reset();
    for (int i = 0; i < DEP; i++) store(BASE + 1, 16'hC000 + 16'(i));
    store(BASE, 16'h0077);
    store(BASE + 1, 16'hC0DE, 1);
    #1 check("R8 ovf", ovf, 0);
    drain(got);
    check("R8 count", got, DEP);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule